// File: doc/BRIEF.md
# Integer Arithmetic Unit with Signed-Overflow Trap

This block is the arithmetic part of the execute stage in a small 32-bit RISC core. It has no clock. From a first operand, a second operand and a 3-bit operation code it forms a 32-bit result in the same cycle. The second operand is either a register value or a 16-bit immediate, which is widened by sign or by zero. The operations are add and subtract, each in a trapping and a non-trapping form, plus signed and unsigned set-less-than.

The trapping and non-trapping forms share one carry-propagate adder and give the same bit pattern. They differ only in overflow reporting. When a trapping form overflows, the unit raises its trap flag and drops its write-enable output, so the destination register keeps its old value. The compare operations return the word 0 or 1. The signed compare takes its answer from the sign of the full 33-bit difference, so the answer stays right even when the 32-bit subtraction wraps. A decoder outside the unit picks the operation, the operand source and the extension mode.

Top module: `int_alu`

## Requirements
- R1: Code 000 (trapping add) and code 001 (non-trapping add) return (A + B) mod 2^32, where B is the selected second operand.
- R2: Code 010 (trapping subtract) and code 011 (non-trapping subtract) return (A - B) mod 2^32. With A = 0 the result is the two's-complement negation of B.
- R3: A trapping add raises `ovf_trap` when both operands have the same sign and the result sign differs from it. A trapping subtract raises `ovf_trap` when the operand signs differ and the result sign differs from A. Otherwise `ovf_trap` stays low.
- R4: The non-trapping codes 001 and 011 never raise `ovf_trap`. Their result equals the result of the trapping form on the same operands.
- R5: `wb_en` is low whenever `ovf_trap` is high. For codes 000 to 101 without a trap, `wb_en` is high.
- R6: Code 100 returns 1 when A < B as two's-complement values and 0 otherwise, with bits 31..1 zero. The answer is correct even when A - B overflows.
- R7: Code 101 returns 1 when A < B as unsigned values and 0 otherwise, with bits 31..1 zero.
- R8: With `b_sel_imm` = 1 the second operand is the 16-bit immediate. With `ext_zero` = 0, bit 15 of the immediate is copied into bits 31..16. With `ext_zero` = 1, bits 31..16 are zero. With `b_sel_imm` = 0 the second operand is `opnd_b_reg`.
- R9: Codes 110 and 111 give a zero result, a low `ovf_trap` and a low `wb_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand |
| opnd_b_reg | input | 32 | Second operand when it comes from a register |
| imm16 | input | 16 | Immediate field |
| b_sel_imm | input | 1 | 1 selects the widened immediate as the second operand |
| ext_zero | input | 1 | 1 widens the immediate by zero fill, 0 by sign copy |
| op_sel | input | 3 | Operation code (000 to 101 valid) |
| result | output | 32 | Arithmetic or compare result |
| ovf_trap | output | 1 | Signed overflow on a trapping operation |
| wb_en | output | 1 | Result may be written to the destination |

## Verification
The bound checker re-evaluates, on every input change, the invariants that can be stated without a full model:
- non-trapping codes never trap;
- a trap always drops the write enable;
- compare results are 0 or 1;
- invalid codes give zero and no write;
- an unsigned register add matches a plain sum;
- the sign rule for a trapping register add;
- zero extension clears the upper half.

Only the bench's directed scenarios can show the exact arithmetic at the overflow boundaries. The same goes for signed compares across a wrapping difference, sign extension of negative immediates, and negation through a zero first operand.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'b000,
    OP_ADDU = 3'b001,
    OP_SUB  = 3'b010,
    OP_SUBU = 3'b011,
    OP_SLT  = 3'b100,
    OP_SLTU = 3'b101
  } alu_op_e;
endpackage

// File: rtl/imm_widen.sv
module imm_widen #(
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              zero_fill,
  output logic [DATA_W-1:0] wide
);
  logic fill_bit;

  assign fill_bit         = zero_fill ? 1'b0 : imm[IMM_W-1];
  assign wide[IMM_W-1:0]  = imm;

  for (genvar gi = IMM_W; gi < DATA_W; gi++) begin : g_upper
    assign wide[gi] = fill_bit;
  end
endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              do_sub,
  output logic [DATA_W-1:0] sum,
  output logic              sgn_ovf,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_inv;
  logic [DATA_W:0]   wide_sum;
  logic              carry_out;

  // The second operand is inverted and carry-in is set for a subtract.
  assign b_inv     = do_sub ? ~b : b;
  assign wide_sum  = {1'b0, a} + {1'b0, b_inv} + {{DATA_W{1'b0}}, do_sub};
  assign sum       = wide_sum[MSB:0];
  assign carry_out = wide_sum[DATA_W];

  // Overflow: like-signed adder inputs give a differently signed sum.
  assign sgn_ovf     = (a[MSB] == b_inv[MSB]) && (sum[MSB] != a[MSB]);
  // Bit 32 of the sign-extended difference gives the true signed order.
  assign lt_signed   = a[MSB] ^ b_inv[MSB] ^ carry_out;
  // No carry out of A + ~B + 1 means A was below B.
  assign lt_unsigned = ~carry_out;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned IW = IMM_W
) (
  input  logic [W-1:0]    opnd_a,
  input  logic [W-1:0]    opnd_b_reg,
  input  logic [IW-1:0]   imm16,
  input  logic            b_sel_imm,
  input  logic            ext_zero,
  input  logic [OP_W-1:0] op_sel,
  output logic [W-1:0]    result,
  output logic            ovf_trap,
  output logic            wb_en
);
  logic [W-1:0] imm_wide;
  logic [W-1:0] opnd_b;
  logic [W-1:0] core_sum;
  logic         core_ovf;
  logic         core_lts;
  logic         core_ltu;
  logic         sub_mode;
  logic         trapping;
  logic         op_valid;

  imm_widen #(.IMM_W(IW), .DATA_W(W)) u_widen (
    .imm       (imm16),
    .zero_fill (ext_zero),
    .wide      (imm_wide)
  );

  assign opnd_b = b_sel_imm ? imm_wide : opnd_b_reg;

  always_comb begin
    sub_mode = 1'b0;
    trapping = 1'b0;
    op_valid = 1'b1;
    case (op_sel)
      OP_ADD:  trapping = 1'b1;
      OP_ADDU: ;
      OP_SUB:  begin sub_mode = 1'b1; trapping = 1'b1; end
      OP_SUBU: sub_mode = 1'b1;
      OP_SLT:  sub_mode = 1'b1;
      OP_SLTU: sub_mode = 1'b1;
      default: op_valid = 1'b0;
    endcase
  end

  addsub_core #(.DATA_W(W)) u_core (
    .a           (opnd_a),
    .b           (opnd_b),
    .do_sub      (sub_mode),
    .sum         (core_sum),
    .sgn_ovf     (core_ovf),
    .lt_signed   (core_lts),
    .lt_unsigned (core_ltu)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result = core_sum;
      OP_SLT:  result = {{(W-1){1'b0}}, core_lts};
      OP_SLTU: result = {{(W-1){1'b0}}, core_ltu};
      default: result = '0;
    endcase
  end

  assign ovf_trap = trapping & core_ovf;
  assign wb_en    = op_valid & ~ovf_trap;
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 16
) (
  input logic [W-1:0]  opnd_a,
  input logic [W-1:0]  opnd_b_reg,
  input logic [IW-1:0] imm16,
  input logic          b_sel_imm,
  input logic          ext_zero,
  input logic [2:0]    op_sel,
  input logic [W-1:0]  result,
  input logic          ovf_trap,
  input logic          wb_en
);
  logic [W-1:0] diff_ab;
  assign diff_ab = result - opnd_a;

  always_comb begin
    if (!b_sel_imm && op_sel == 3'b001)
      assert_plain_sum_R1: assert (diff_ab == opnd_b_reg);

    if (!b_sel_imm && op_sel == 3'b000 && opnd_a[W-1] == opnd_b_reg[W-1]
        && result[W-1] != opnd_a[W-1])
      assert_add_trap_R3: assert (ovf_trap);

    if (op_sel == 3'b001 || op_sel == 3'b011)
      assert_no_overflow_R4: assert (!ovf_trap);

    if (ovf_trap)
      assert_trap_blocks_write_R5: assert (!wb_en);

    if (op_sel == 3'b100)
      assert_slt_bool_R6: assert (result[W-1:1] == '0);

    if (op_sel == 3'b101)
      assert_sltu_bool_R7: assert (result[W-1:1] == '0);

    if (b_sel_imm && ext_zero && op_sel == 3'b001 && opnd_a == '0)
      assert_zero_fill_R8: assert (result[W-1:IW] == '0);

    if (op_sel == 3'b110 || op_sel == 3'b111)
      assert_invalid_idle_R9: assert (!wb_en && !ovf_trap && result == '0);
  end
endmodule

bind int_alu int_alu_checker #(.W(W), .IW(IW)) u_checker (
  .opnd_a     (opnd_a),
  .opnd_b_reg (opnd_b_reg),
  .imm16      (imm16),
  .b_sel_imm  (b_sel_imm),
  .ext_zero   (ext_zero),
  .op_sel     (op_sel),
  .result     (result),
  .ovf_trap   (ovf_trap),
  .wb_en      (wb_en)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b_reg;
  logic [15:0] imm16;
  logic        b_sel_imm;
  logic        ext_zero;
  logic [2:0]  op_sel;
  logic [31:0] result;
  logic        ovf_trap;
  logic        wb_en;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int_alu uut (
    .opnd_a     (opnd_a),
    .opnd_b_reg (opnd_b_reg),
    .imm16      (imm16),
    .b_sel_imm  (b_sel_imm),
    .ext_zero   (ext_zero),
    .op_sel     (op_sel),
    .result     (result),
    .ovf_trap   (ovf_trap),
    .wb_en      (wb_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic o, output logic w);
    longint sa, sb, full;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    o = 1'b0;
    w = 1'b1;
    case (op)
      3'b000, 3'b001: begin
        full = sa + sb;
        r = full[31:0];
        if (op == 3'b000 && (full > 64'sd2147483647 || full < -64'sd2147483648)) o = 1'b1;
      end
      3'b010, 3'b011: begin
        full = sa - sb;
        r = full[31:0];
        if (op == 3'b010 && (full > 64'sd2147483647 || full < -64'sd2147483648)) o = 1'b1;
      end
      3'b100: r = (sa < sb) ? 32'd1 : 32'd0;
      3'b101: r = ({32'd0, a} < {32'd0, b}) ? 32'd1 : 32'd0;
      default: begin r = 32'd0; w = 1'b0; end
    endcase
    if (o) w = 1'b0;
  endtask

  task automatic run_op(input string tag, input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] breg, input logic [15:0] imm,
                        input logic sel, input logic zx);
    logic [31:0] beff, er;
    logic eo, ew;
    beff = sel ? (zx ? {16'h0000, imm} : {{16{imm[15]}}, imm}) : breg;
    model(op, a, beff, er, eo, ew);
    @(posedge clk);
    op_sel = op; opnd_a = a; opnd_b_reg = breg; imm16 = imm; b_sel_imm = sel; ext_zero = zx;
    @(negedge clk);
    total++;
    if (result !== er || ovf_trap !== eo || wb_en !== ew) begin
      bad++;
      $display("FAIL %s: got result=%h ovf=%b we=%b expected result=%h ovf=%b we=%b",
               tag, result, ovf_trap, wb_en, er, eo, ew);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    total++;
    if (result !== 32'd0 || ovf_trap !== 1'b0 || wb_en !== 1'b1) begin
      bad++;
      $display("FAIL R1 reset: got result=%h ovf=%b we=%b expected 0 0 1",
               result, ovf_trap, wb_en);
    end
  endtask

  task automatic t_add();
    run_op("R1 add small",     3'b000, 32'd5, 32'd7, 16'h0, 1'b0, 1'b0);
    run_op("R1 addu wrap",     3'b001, 32'hFFFF_FFFF, 32'd2, 16'h0, 1'b0, 1'b0);
    run_op("R1 add neg+pos",   3'b000, 32'hFFFF_FFF0, 32'h0000_0020, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_sub();
    run_op("R2 sub",           3'b010, 32'd100, 32'd58, 16'h0, 1'b0, 1'b0);
    run_op("R2 negate",        3'b010, 32'd0, 32'd9, 16'h0, 1'b0, 1'b0);
    run_op("R2 subu borrow",   3'b011, 32'd3, 32'd4, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    run_op("R3 add pos ovf",   3'b000, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R3 add neg ovf",   3'b000, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);
    run_op("R3 sub ovf",       3'b010, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R3 negate min",    3'b010, 32'd0, 32'h8000_0000, 16'h0, 1'b0, 1'b0);
    run_op("R3 sub no ovf",    3'b010, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 1'b0, 1'b0);
    run_op("R4 addu no trap",  3'b001, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R4 subu no trap",  3'b011, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R5 max edge",      3'b000, 32'h7FFF_FFFE, 32'd1, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_compare();
    run_op("R6 slt neg<pos",   3'b100, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R6 slt wrap 0",    3'b100, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 1'b0, 1'b0);
    run_op("R6 slt wrap 1",    3'b100, 32'h8000_0000, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R6 slt equal",     3'b100, 32'd42, 32'd42, 16'h0, 1'b0, 1'b0);
    run_op("R7 sltu big",      3'b101, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R7 sltu small",    3'b101, 32'd1, 32'hFFFF_FFFF, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic t_immediate();
    run_op("R8 sign ext neg",  3'b001, 32'd0, 32'hDEAD_BEEF, 16'h8001, 1'b1, 1'b0);
    run_op("R8 zero ext",      3'b001, 32'd0, 32'hDEAD_BEEF, 16'h8001, 1'b1, 1'b1);
    run_op("R8 addi trap",     3'b000, 32'h7FFF_FFFF, 32'd0, 16'h0001, 1'b1, 1'b0);
    run_op("R8 slti neg imm",  3'b100, 32'd0, 32'd0, 16'hFFFF, 1'b1, 1'b0);
    run_op("R8 sltiu neg imm", 3'b101, 32'd5, 32'd0, 16'hFFFF, 1'b1, 1'b0);
  endtask

  task automatic t_invalid();
    run_op("R9 code 110",      3'b110, 32'h7FFF_FFFF, 32'd1, 16'h0, 1'b0, 1'b0);
    run_op("R9 code 111",      3'b111, 32'h1234_5678, 32'h1111_1111, 16'h0, 1'b0, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    opnd_a = '0; opnd_b_reg = '0; imm16 = '0;
    b_sel_imm = 1'b0; ext_zero = 1'b0; op_sel = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_add();
    t_sub();
    t_overflow();
    t_compare();
    t_immediate();
    t_invalid();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule